// File: doc/BRIEF.md
# Virtual Interrupt List Register Bank

This block is a small bank of list registers. Each register presents one virtual interrupt to a guest CPU interface. An entry holds four things: a virtual interrupt ID, a two-bit state, a link flag, and a physical interrupt ID. The link flag ties the entry to a physical source. The host loads or clears an entry through a write port and can read any entry back.

The guest interacts with the bank through two strobes:
- An acknowledge strobe returns the ID of a pending interrupt and makes that entry active.
- A deactivate strobe retires an active interrupt by its virtual ID.

When the retired entry is linked, the block does not touch the entry's state. It raises a one-cycle request toward the physical distributor, carrying the stored physical ID. The host later clears that entry with an explicit write.

A linked entry is never allowed to be pending and active at the same time. The block refuses a host write that asks for that combination and raises an error strobe.

Top module: `virq_list_bank`

## Requirements
- R1: After reset, every entry reads back as state 00 (inactive) with link 0, and `ackValid`, `physDeactValid` and `hostWrErr` are low.
- R2: An accepted host write stores ID, state, link and physical ID into entry `hostIdx` at the clock edge. The host read outputs show entry `hostIdx` without delay. State bit 0 means pending and bit 1 means active, so 01 is pending, 10 is active and 11 is pending+active. Writing state 00 clears the entry.
- R3: A host write with link 1 and state 11 is rejected and leaves the entry unchanged. One cycle later, `hostWrErr` is high for exactly that cycle.
- R4: When `guestAckReq` is high, the lowest-index entry with its pending bit set is selected. In the next cycle `ackValid` is 1 and `ackId` carries that entry's virtual ID, and the entry's state becomes 10 (active).
- R5: An acknowledge with no pending entry returns the spurious ID of all ones (1023 at 10 bits) and changes no entry.
- R6: A deactivate of an unlinked entry clears that entry's active bit, so 10 becomes 00 and 11 becomes 01. The target is the lowest-index entry whose active bit is set and whose virtual ID equals `guestDeactId`.
- R7: A deactivate that hits a linked entry leaves the entry's state unchanged. In the next cycle `physDeactValid` is 1 and `physDeactId` equals the entry's physical ID.
- R8: A deactivate that matches no active entry changes no entry and raises no physical request.
- R9: When an accepted host write and a guest acknowledge or deactivate target the same entry in the same cycle, the host write decides the entry's new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host write strobe |
| hostIdx | input | 2 | Entry index for host write and read |
| hostWrVid | input | 10 | Virtual ID to write |
| hostWrState | input | 2 | State to write (bit0 pending, bit1 active) |
| hostWrLink | input | 1 | Link flag to write |
| hostWrPid | input | 10 | Physical ID to write |
| hostWrErr | output | 1 | One-cycle strobe for a rejected write |
| hostRdVid | output | 10 | Virtual ID of entry `hostIdx` |
| hostRdState | output | 2 | State of entry `hostIdx` |
| hostRdLink | output | 1 | Link flag of entry `hostIdx` |
| hostRdPid | output | 10 | Physical ID of entry `hostIdx` |
| guestAckReq | input | 1 | Guest acknowledge read strobe |
| ackValid | output | 1 | Acknowledge result valid |
| ackId | output | 10 | Acknowledged virtual ID or all ones |
| guestDeactReq | input | 1 | Guest deactivate strobe |
| guestDeactId | input | 10 | Virtual ID being deactivated |
| physDeactValid | output | 1 | Deactivate request to the distributor |
| physDeactId | output | 10 | Physical ID of that request |

## Verification
The bench builds the bank with its default parameters: four entries and 10-bit IDs. With four entries, random traffic easily fills several entries with the same small virtual IDs. That brings the lowest-index rule for both acknowledge and deactivate within reach. The 10-bit width makes the spurious value 1023 distinct from every loaded ID. Random cycles mix host writes, acknowledges and deactivates in the same cycle, which reaches the precedence rule and the rejected linked pending+active write many times.

// File: rtl/vlr_pkg.sv
package vlr_pkg;
  localparam logic [1:0] ST_IDLE = 2'b00;
  localparam logic [1:0] ST_PEND = 2'b01;
  localparam logic [1:0] ST_ACT  = 2'b10;
  localparam logic [1:0] ST_BOTH = 2'b11;

  typedef struct packed {
    logic wrAccept;
    logic wrReject;
    logic ackHit;
    logic ackReq;
    logic deactHit;
    logic deactLinked;
  } ctrlStrobes_t;
endpackage

// File: rtl/vlr_control.sv
module vlr_control #(
  parameter int NUM_ENTRIES = 4,
  parameter int VID_W = 10,
  parameter int IDX_W = 2
) (
  input  logic                                hostWrEn,
  input  logic                                hostWrLink,
  input  logic [1:0]                          hostWrState,
  input  logic                                guestAckReq,
  input  logic                                guestDeactReq,
  input  logic [VID_W-1:0]                    guestDeactId,
  input  logic [NUM_ENTRIES-1:0][1:0]         entState,
  input  logic [NUM_ENTRIES-1:0]              entLink,
  input  logic [NUM_ENTRIES-1:0][VID_W-1:0]   entVid,
  output vlr_pkg::ctrlStrobes_t               strobes,
  output logic [IDX_W-1:0]                    ackIdx,
  output logic [IDX_W-1:0]                    deactIdx
);
  logic pendFound;
  logic actFound;

  // lowest index wins: scan downward so the last assignment is the smallest index
  always_comb begin
    pendFound = 1'b0;
    ackIdx    = '0;
    actFound  = 1'b0;
    deactIdx  = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (entState[i][0]) begin
        pendFound = 1'b1;
        ackIdx    = IDX_W'(i);
      end
      if (entState[i][1] && (entVid[i] == guestDeactId)) begin
        actFound = 1'b1;
        deactIdx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    strobes.wrReject    = hostWrEn && hostWrLink && (hostWrState == vlr_pkg::ST_BOTH);
    strobes.wrAccept    = hostWrEn && !strobes.wrReject;
    strobes.ackReq      = guestAckReq;
    strobes.ackHit      = guestAckReq && pendFound;
    strobes.deactHit    = guestDeactReq && actFound;
    strobes.deactLinked = guestDeactReq && actFound && entLink[deactIdx];
  end
endmodule

// File: rtl/vlr_datapath.sv
module vlr_datapath #(
  parameter int NUM_ENTRIES = 4,
  parameter int VID_W = 10,
  parameter int PID_W = 10,
  parameter int IDX_W = 2
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  vlr_pkg::ctrlStrobes_t               strobes,
  input  logic [IDX_W-1:0]                    ackIdx,
  input  logic [IDX_W-1:0]                    deactIdx,
  input  logic [IDX_W-1:0]                    hostIdx,
  input  logic [VID_W-1:0]                    hostWrVid,
  input  logic [1:0]                          hostWrState,
  input  logic                                hostWrLink,
  input  logic [PID_W-1:0]                    hostWrPid,
  output logic [NUM_ENTRIES-1:0][1:0]         entState,
  output logic [NUM_ENTRIES-1:0]              entLink,
  output logic [NUM_ENTRIES-1:0][VID_W-1:0]   entVid,
  output logic [VID_W-1:0]                    hostRdVid,
  output logic [1:0]                          hostRdState,
  output logic                                hostRdLink,
  output logic [PID_W-1:0]                    hostRdPid,
  output logic                                hostWrErr,
  output logic                                ackValid,
  output logic [VID_W-1:0]                    ackId,
  output logic                                physDeactValid,
  output logic [PID_W-1:0]                    physDeactId
);
  localparam logic [VID_W-1:0] SPURIOUS_ID = '1;

  logic [NUM_ENTRIES-1:0][PID_W-1:0] entPid;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
    logic wrSel, ackSel, deactSel;
    assign wrSel    = strobes.wrAccept && (hostIdx == IDX_W'(g));
    assign ackSel   = strobes.ackHit && (ackIdx == IDX_W'(g));
    assign deactSel = strobes.deactHit && (deactIdx == IDX_W'(g)) && !entLink[g];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        entState[g] <= vlr_pkg::ST_IDLE;
        entLink[g]  <= 1'b0;
        entVid[g]   <= '0;
        entPid[g]   <= '0;
      end else if (wrSel) begin
        entState[g] <= hostWrState;
        entLink[g]  <= hostWrLink;
        entVid[g]   <= hostWrVid;
        entPid[g]   <= hostWrPid;
      end else if (ackSel) begin
        entState[g] <= vlr_pkg::ST_ACT;
      end else if (deactSel) begin
        entState[g] <= {1'b0, entState[g][0]};
      end
    end

    // R3: a linked entry never holds pending and active together
    a_r3_linked_never_both: assert property (@(posedge clk) disable iff (!rstN)
      entLink[g] |-> (entState[g] != vlr_pkg::ST_BOTH));
  end

  always_comb begin
    hostRdVid   = entVid[hostIdx];
    hostRdState = entState[hostIdx];
    hostRdLink  = entLink[hostIdx];
    hostRdPid   = entPid[hostIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostWrErr      <= 1'b0;
      ackValid       <= 1'b0;
      ackId          <= '0;
      physDeactValid <= 1'b0;
      physDeactId    <= '0;
    end else begin
      hostWrErr      <= strobes.wrReject;
      ackValid       <= strobes.ackReq;
      ackId          <= strobes.ackHit ? entVid[ackIdx] : SPURIOUS_ID;
      physDeactValid <= strobes.deactLinked;
      physDeactId    <= entPid[deactIdx];
    end
  end

  // R3: error strobe only after a linked pending+active write request
  a_r3_err_cause: assert property (@(posedge clk) disable iff (!rstN)
    hostWrErr |-> ($past(hostWrLink) && ($past(hostWrState) == vlr_pkg::ST_BOTH)));

  // R4: every acknowledge result follows an acknowledge strobe one cycle earlier
  a_r4_ack_timing: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> $past(strobes.ackReq));

  // R4: an acknowledged entry is active and not pending one cycle later unless rewritten
  a_r4_ack_moves_to_active: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.ackHit && !(strobes.wrAccept && hostIdx == ackIdx)) |=> (entState[$past(ackIdx)] == vlr_pkg::ST_ACT));

  // R7: a distributor request only follows a guest deactivate
  a_r7_phys_from_deact: assert property (@(posedge clk) disable iff (!rstN)
    physDeactValid |-> $past(strobes.deactHit));
endmodule

// File: rtl/virq_list_bank.sv
module virq_list_bank #(
  parameter int NUM_ENTRIES = 4,
  parameter int VID_W = 10,
  parameter int PID_W = 10,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostWrEn,
  input  logic [IDX_W-1:0] hostIdx,
  input  logic [VID_W-1:0] hostWrVid,
  input  logic [1:0]       hostWrState,
  input  logic             hostWrLink,
  input  logic [PID_W-1:0] hostWrPid,
  output logic             hostWrErr,
  output logic [VID_W-1:0] hostRdVid,
  output logic [1:0]       hostRdState,
  output logic             hostRdLink,
  output logic [PID_W-1:0] hostRdPid,
  input  logic             guestAckReq,
  output logic             ackValid,
  output logic [VID_W-1:0] ackId,
  input  logic             guestDeactReq,
  input  logic [VID_W-1:0] guestDeactId,
  output logic             physDeactValid,
  output logic [PID_W-1:0] physDeactId
);
  vlr_pkg::ctrlStrobes_t               strobes;
  logic [IDX_W-1:0]                    ackIdx, deactIdx;
  logic [NUM_ENTRIES-1:0][1:0]         entState;
  logic [NUM_ENTRIES-1:0]              entLink;
  logic [NUM_ENTRIES-1:0][VID_W-1:0]   entVid;

  vlr_control #(.NUM_ENTRIES(NUM_ENTRIES), .VID_W(VID_W), .IDX_W(IDX_W)) i_control (
    .hostWrEn(hostWrEn), .hostWrLink(hostWrLink), .hostWrState(hostWrState),
    .guestAckReq(guestAckReq), .guestDeactReq(guestDeactReq), .guestDeactId(guestDeactId),
    .entState(entState), .entLink(entLink), .entVid(entVid),
    .strobes(strobes), .ackIdx(ackIdx), .deactIdx(deactIdx)
  );

  vlr_datapath #(.NUM_ENTRIES(NUM_ENTRIES), .VID_W(VID_W), .PID_W(PID_W), .IDX_W(IDX_W)) i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .ackIdx(ackIdx), .deactIdx(deactIdx),
    .hostIdx(hostIdx), .hostWrVid(hostWrVid), .hostWrState(hostWrState),
    .hostWrLink(hostWrLink), .hostWrPid(hostWrPid),
    .entState(entState), .entLink(entLink), .entVid(entVid),
    .hostRdVid(hostRdVid), .hostRdState(hostRdState), .hostRdLink(hostRdLink),
    .hostRdPid(hostRdPid), .hostWrErr(hostWrErr), .ackValid(ackValid), .ackId(ackId),
    .physDeactValid(physDeactValid), .physDeactId(physDeactId)
  );
endmodule

// File: tb/test_virq_list_bank.sv
module test_virq_list_bank;
  localparam int N = 4;
  localparam int VW = 10;
  localparam int PW = 10;
  localparam logic [VW-1:0] SPUR = '1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWrEn = 1'b0;
  logic [1:0] hostIdx = '0;
  logic [VW-1:0] hostWrVid = '0;
  logic [1:0] hostWrState = '0;
  logic hostWrLink = 1'b0;
  logic [PW-1:0] hostWrPid = '0;
  logic hostWrErr;
  logic [VW-1:0] hostRdVid;
  logic [1:0] hostRdState;
  logic hostRdLink;
  logic [PW-1:0] hostRdPid;
  logic guestAckReq = 1'b0;
  logic ackValid;
  logic [VW-1:0] ackId;
  logic guestDeactReq = 1'b0;
  logic [VW-1:0] guestDeactId = '0;
  logic physDeactValid;
  logic [PW-1:0] physDeactId;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [VW-1:0] mVid [N];
  logic [1:0]    mState [N];
  logic          mLink [N];
  logic [PW-1:0] mPid [N];

  always #5 clk = ~clk;

  virq_list_bank i_virq_list_bank (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lowestPending();
    for (int i = 0; i < N; i++) if (mState[i][0]) return i;
    return -1;
  endfunction

  function automatic int deactTarget(input logic [VW-1:0] id);
    for (int i = 0; i < N; i++) if (mState[i][1] && mVid[i] == id) return i;
    return -1;
  endfunction

  // one clock with the given stimulus; checks registered outputs and updates the model
  task automatic cycle(input bit we, input int idx, input int vid, input int st, input bit lnk,
                       input int pid, input bit ack, input bit dq, input int did, input string tag);
    int ai, di;
    bit rej, expPhys;
    logic [VW-1:0] expAck;
    logic [PW-1:0] expPid;
    hostWrEn = we; hostIdx = 2'(idx); hostWrVid = VW'(vid); hostWrState = 2'(st);
    hostWrLink = lnk; hostWrPid = PW'(pid);
    guestAckReq = ack; guestDeactReq = dq; guestDeactId = VW'(did);
    rej = we && lnk && (st == 3);
    ai = ack ? lowestPending() : -1;
    di = dq ? deactTarget(VW'(did)) : -1;
    expAck = (ai >= 0) ? mVid[ai] : SPUR;
    expPhys = (di >= 0) && mLink[di];
    expPid = expPhys ? mPid[di] : '0;
    @(posedge clk);
    @(negedge clk);
    hostWrEn = 1'b0; guestAckReq = 1'b0; guestDeactReq = 1'b0;
    chk(hostWrErr == rej, {tag, " R3 err strobe"}, hostWrErr, rej);
    chk(ackValid == ack, {tag, " R4 ackValid"}, ackValid, ack);
    if (ack) chk(ackId == expAck, (ai >= 0) ? {tag, " R4 ackId"} : {tag, " R5 spurious"}, ackId, expAck);
    chk(physDeactValid == expPhys, (di >= 0) ? {tag, " R7 phys strobe"} : {tag, " R8 no phys"},
        physDeactValid, expPhys);
    if (expPhys) chk(physDeactId == expPid, {tag, " R7 phys id"}, physDeactId, expPid);
    for (int i = 0; i < N; i++) begin
      if (we && !rej && idx == i) begin
        mVid[i] = VW'(vid); mState[i] = 2'(st); mLink[i] = lnk; mPid[i] = PW'(pid);
      end else if (ai == i) begin
        mState[i] = 2'b10;
      end else if (di == i && !mLink[i]) begin
        mState[i][1] = 1'b0;
      end
    end
  endtask

  task automatic checkEntries(input string tag);
    for (int i = 0; i < N; i++) begin
      hostIdx = 2'(i);
      #1;
      chk(hostRdState == mState[i], {tag, " R2 state"}, hostRdState, mState[i]);
      chk(hostRdVid == mVid[i], {tag, " R2 vid"}, hostRdVid, mVid[i]);
      chk(hostRdLink == mLink[i], {tag, " R2 link"}, hostRdLink, mLink[i]);
      chk(hostRdPid == mPid[i], {tag, " R2 pid"}, hostRdPid, mPid[i]);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(10 * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      mVid[i] = '0; mState[i] = '0; mLink[i] = 1'b0; mPid[i] = '0;
    end
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk(!ackValid && !physDeactValid && !hostWrErr, "R1 outputs low", ackValid, 0);
    checkEntries("R1 reset");

    // directed: load two entries
    cycle(1, 0, 5, 1, 0, 0, 0, 0, 0, "R2 load unlinked");
    cycle(1, 1, 7, 1, 1, 300, 0, 0, 0, "R2 load linked");
    checkEntries("R2 directed");
    cycle(0, 0, 0, 0, 0, 0, 1, 0, 0, "R4 first ack");
    chk(ackId == 10'd5, "R4 lowest index vid", ackId, 5);
    cycle(0, 0, 0, 0, 0, 0, 1, 0, 0, "R4 second ack");
    chk(ackId == 10'd7, "R4 next pending vid", ackId, 7);
    cycle(0, 0, 0, 0, 0, 0, 1, 0, 0, "R5 empty ack");
    chk(ackId == SPUR, "R5 spurious value", ackId, SPUR);
    cycle(0, 0, 0, 0, 0, 0, 0, 1, 7, "R7 linked deact");
    chk(physDeactValid && physDeactId == 10'd300, "R7 phys id 300", physDeactId, 300);
    hostIdx = 2'd1; #1;
    chk(hostRdState == 2'b10, "R7 linked stays active", hostRdState, 2);
    cycle(0, 0, 0, 0, 0, 0, 0, 1, 5, "R6 unlinked deact");
    hostIdx = 2'd0; #1;
    chk(hostRdState == 2'b00, "R6 active to inactive", hostRdState, 0);
    cycle(0, 0, 0, 0, 0, 0, 0, 1, 9, "R8 unmatched deact");
    checkEntries("R8 unchanged");
    cycle(1, 2, 11, 3, 1, 40, 0, 0, 0, "R3 linked both");
    chk(hostWrErr, "R3 error raised", hostWrErr, 1);
    checkEntries("R3 unchanged");
    cycle(1, 2, 12, 3, 0, 0, 0, 0, 0, "R6 load both");
    cycle(0, 0, 0, 0, 0, 0, 0, 1, 12, "R6 both deact");
    hostIdx = 2'd2; #1;
    chk(hostRdState == 2'b01, "R6 both to pending", hostRdState, 1);
    cycle(1, 2, 20, 1, 0, 0, 1, 0, 0, "R9 write vs ack");
    hostIdx = 2'd2; #1;
    chk(hostRdState == 2'b01 && hostRdVid == 10'd20, "R9 write wins", hostRdState, 1);
    cycle(1, 1, 0, 0, 0, 0, 0, 0, 0, "R2 host clear");
    checkEntries("R2 clear");

    // constrained random
    for (int n = 0; n < 600; n++) begin
      bit we, ack, dq, lnk;
      int st;
      we = ($urandom_range(0, 2) == 0);
      ack = ($urandom_range(0, 2) == 0);
      dq = ($urandom_range(0, 2) == 0);
      lnk = $urandom_range(0, 1);
      st = $urandom_range(0, 3);
      cycle(we, $urandom_range(0, N - 1), $urandom_range(0, 5), st, lnk,
            $urandom_range(0, 1000), ack, dq, $urandom_range(0, 5), "rand");
      if (n % 4 == 0) checkEntries("rand");
    end
    finishRun();
  end
endmodule